// File: doc/BRIEF.md
# Dual-Rate Stream Cipher Phase Sequencer

This block steps a shift-register based stream cipher core through its life cycle using nothing but enables. After a start pulse it asks the core to capture its key and initial value, then clocks the core through a warm-up whose feedback path is long, then through a shorter accumulator fill, and finally into keystream production. Only one clock enters the block. The warm-up runs at a reduced rate, produced by a counter as a one-cycle step strobe every `DIV_RATIO` fast cycles. All later phases step at the full clock rate.

Phase lengths are counted in core steps, not in clock cycles, so the warm-up always takes exactly `INIT_STEPS` steps whatever the divide ratio. The keystream side has an isolation register between the core's output function and the consumer. Each produced bit therefore appears one cycle after the step that made it. Downstream sees a valid/ready stream. While `ks_valid_o` is high and `ks_ready_i` is low, the held beat and its `tag_last_o` flag stay unchanged and the core is not stepped. A new step happens only when the stage is empty or is being drained in the same cycle, so a ready consumer receives one bit per cycle. `tag_last_o` marks every `TAG_BITS`-th beat of the stream, where the tag length is at most 32.

A start pulse is honoured only in the idle phase. Reset is the only way back to idle.

Top module: `cipher_phase_seq`

## Requirements
- R1: During and after reset, with no start accepted, `phase_o` is 0 (idle), and `load_en_o`, `step_en_o` and `ks_valid_o` are low.
- R2: A start sampled high in idle gives exactly one cycle with `phase_o` = 1 (load), `load_en_o` high and `step_en_o` low. `phase_o` = 2 (warm-up) follows.
- R3: In warm-up, `step_en_o` is high only in every `DIV_RATIO`-th cycle, counting from the first warm-up cycle as cycle 0 (high where index mod `DIV_RATIO` = `DIV_RATIO`-1).
- R4: `ks_valid_o` stays low in the load, warm-up (`phase_o` = 2) and fill (`phase_o` = 3) phases.
- R5: In fill, `step_en_o` is high in every cycle. The phase lasts exactly `AUTH_STEPS` cycles, and `phase_o` then becomes 4 (operation) and stays there.
- R6: In operation, a cycle with `step_en_o` high is followed by `ks_valid_o` high in the next cycle (one-cycle isolation latency). `step_en_o` is high whenever `ks_valid_o` is low or `ks_ready_i` is high.
- R7: While `ks_valid_o` is high and `ks_ready_i` is low, `step_en_o` is low, and in the next cycle `ks_valid_o` is still high and `tag_last_o` is unchanged.
- R8: Numbering the operational steps from 1 after entering operation, `tag_last_o` is high with the beat of step k exactly when k mod `TAG_BITS` = 0.
- R9: A start pulse outside idle has no effect on `phase_o` or on the step sequence.
- R10: Warm-up contains exactly `INIT_STEPS` cycles with `step_en_o` high and lasts `INIT_STEPS`*`DIV_RATIO` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, honoured only in idle |
| phase_o | output | 3 | Phase code: 0 idle, 1 load, 2 warm-up, 3 fill, 4 operation |
| load_en_o | output | 1 | Core captures key and initial value |
| step_en_o | output | 1 | Core state registers advance one step |
| ks_valid_o | output | 1 | Keystream beat held in the isolation stage is valid |
| ks_ready_i | input | 1 | Consumer accepts the current beat |
| tag_last_o | output | 1 | Current beat closes a tag word |

## Verification
The bench builds the block with `DIV_RATIO` = 3, `INIT_STEPS` = 12, `AUTH_STEPS` = 5 and `TAG_BITS` = 4. This keeps a whole run from start to deep into operation under a hundred cycles, so every cycle of every phase is compared with an arithmetic schedule. A ratio of 3 separates step counts from cycle counts and exposes an off-by-one in the strobe position. The short tag length makes the tag marker wrap several times under always-ready, periodic and bursty back-pressure, and start pulses are injected during warm-up and operation.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LOAD = 3'd1,
    PH_INIT = 3'd2,
    PH_AUTH = 3'd3,
    PH_OPER = 3'd4
  } phase_e;
endpackage

// File: rtl/cps_rate_div.sv
// Reduced-rate step strobe: one cycle high every DIV_RATIO cycles while run is high.
module cps_rate_div #(
  parameter int DIV_RATIO = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (DIV_RATIO <= 1) begin : g_full
      assign tick = run;
    end else begin : g_div
      localparam int CW = $clog2(DIV_RATIO);
      localparam logic [CW-1:0] TOP = CW'(DIV_RATIO - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!run)       cnt_q <= '0;
        else if (cnt_q == TOP) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
      end

      assign tick = run && (cnt_q == TOP);
    end
  endgenerate
endmodule

// File: rtl/cps_step_ctr.sv
// Counts enabled steps; flags the step that completes LIMIT steps, then wraps.
module cps_step_ctr #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last_step
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);
  logic [CW-1:0] cnt_q;

  assign last_step = inc && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (clr)       cnt_q <= '0;
    else if (last_step) cnt_q <= '0;
    else if (inc)       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cps_out_stage.sv
// Isolation register on the keystream side, exposed as a valid/ready beat.
module cps_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic step,
  input  logic last_in,
  input  logic ready,
  output logic can_step,
  output logic valid,
  output logic last
);
  assign can_step = !valid || ready;

  always_ff @(posedge clk) begin
    if (!rst_n)     valid <= 1'b0;
    else if (flush) valid <= 1'b0;
    else if (step)  valid <= 1'b1;
    else if (ready) valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     last <= 1'b0;
    else if (flush) last <= 1'b0;
    else if (step)  last <= last_in;
  end
endmodule

// File: rtl/cipher_phase_seq.sv
module cipher_phase_seq #(
  parameter int DIV_RATIO  = 2,
  parameter int INIT_STEPS = 256,
  parameter int AUTH_STEPS = 64,
  parameter int TAG_BITS   = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  output logic [2:0] phase_o,
  output logic       load_en_o,
  output logic       step_en_o,
  output logic       ks_valid_o,
  input  logic       ks_ready_i,
  output logic       tag_last_o
);
  import cps_pkg::*;

  phase_e phase_q, phase_d;
  logic in_init, in_auth, in_oper;
  logic init_tick, init_done, auth_done, tag_wrap;
  logic can_step, oper_step;

  assign in_init = (phase_q == PH_INIT);
  assign in_auth = (phase_q == PH_AUTH);
  assign in_oper = (phase_q == PH_OPER);

  // slow-rate strobe for the warm-up phase
  cps_rate_div #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk(clk), .rst_n(rst_n), .run(in_init), .tick(init_tick)
  );

  // warm-up step count
  cps_step_ctr #(.LIMIT(INIT_STEPS)) u_init_ctr (
    .clk(clk), .rst_n(rst_n), .clr(!in_init), .inc(init_tick), .last_step(init_done)
  );

  // accumulator fill step count (full rate)
  cps_step_ctr #(.LIMIT(AUTH_STEPS)) u_auth_ctr (
    .clk(clk), .rst_n(rst_n), .clr(!in_auth), .inc(in_auth), .last_step(auth_done)
  );

  // tag word boundary in operation
  cps_step_ctr #(.LIMIT(TAG_BITS)) u_tag_ctr (
    .clk(clk), .rst_n(rst_n), .clr(!in_oper), .inc(oper_step), .last_step(tag_wrap)
  );

  assign oper_step = in_oper && can_step;

  cps_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .flush(!in_oper), .step(oper_step),
    .last_in(tag_wrap), .ready(ks_ready_i), .can_step(can_step),
    .valid(ks_valid_o), .last(tag_last_o)
  );

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start_i)   phase_d = PH_LOAD;
      PH_LOAD:                phase_d = PH_INIT;
      PH_INIT: if (init_done) phase_d = PH_AUTH;
      PH_AUTH: if (auth_done) phase_d = PH_OPER;
      PH_OPER:                phase_d = PH_OPER;
      default:                phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase_o   = phase_q;
  assign load_en_o = (phase_q == PH_LOAD);
  assign step_en_o = init_tick || in_auth || oper_step;
endmodule

// File: rtl/cps_checks.sv
module cps_checks #(
  parameter int DIV_RATIO = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [2:0] phase_o,
  input logic       load_en_o,
  input logic       step_en_o,
  input logic       ks_valid_o,
  input logic       ks_ready_i,
  input logic       tag_last_o
);
  import cps_pkg::*;

  // cycles in warm-up since entry or since the last step
  int gap_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                                  gap_q <= 0;
    else if (phase_o != PH_INIT || step_en_o)    gap_q <= 0;
    else                                         gap_q <= gap_q + 1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_IDLE) |-> (!load_en_o && !step_en_o && !ks_valid_o));

  assert_load_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_LOAD) |-> (load_en_o && !step_en_o) ##1 (phase_o == PH_INIT));

  assert_init_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_INIT) |-> (step_en_o == (gap_q == DIV_RATIO - 1)));

  assert_no_warmup_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_LOAD || phase_o == PH_INIT || phase_o == PH_AUTH) |-> !ks_valid_o);

  assert_fill_full_rate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_AUTH) |-> step_en_o);

  assert_oper_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_OPER) |=> (phase_o == PH_OPER));

  assert_valid_after_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_OPER && step_en_o) |=> ks_valid_o);

  assert_step_when_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_OPER && (!ks_valid_o || ks_ready_i)) |-> step_en_o);

  assert_hold_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_valid_o && !ks_ready_i) |-> !step_en_o ##1 (ks_valid_o && $stable(tag_last_o)));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != PH_IDLE && start_i) |=> (phase_o != PH_LOAD));
endmodule

bind cipher_phase_seq cps_checks #(.DIV_RATIO(DIV_RATIO)) u_cps_checks (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .phase_o(phase_o),
  .load_en_o(load_en_o), .step_en_o(step_en_o), .ks_valid_o(ks_valid_o),
  .ks_ready_i(ks_ready_i), .tag_last_o(tag_last_o)
);

// File: tb/tb_cipher_phase_seq.sv
`timescale 1ns/1ps
module tb_cipher_phase_seq;
  localparam int D = 3;
  localparam int I = 12;
  localparam int A = 5;
  localparam int T = 4;
  localparam int OPER_START = 2 + I * D + A;
  localparam int OPER_RUN   = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ready = 1'b1;
  logic [2:0] phase;
  logic load_en, step_en, valid, tlast;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cipher_phase_seq #(.DIV_RATIO(D), .INIT_STEPS(I), .AUTH_STEPS(A), .TAG_BITS(T)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .phase_o(phase),
    .load_en_o(load_en), .step_en_o(step_en), .ks_valid_o(valid),
    .ks_ready_i(ready), .tag_last_o(tlast)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d @%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_phase(input int n);
    if (n <= 0) return 0;
    if (n == 1) return 1;
    if (n < 2 + I * D) return 2;
    if (n < OPER_START) return 3;
    return 4;
  endfunction

  function automatic string phase_req(input int p);
    case (p)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic ready_pat(input int mode, input int n);
    case (mode)
      0: return 1'b1;
      1: return (n % 3) != 0;
      default: return ((n / 4) % 2) == 0;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    #1;
    chk("R1", "phase in reset", int'(phase), 0);
    chk("R1", "step_en in reset", int'(step_en), 0);
    chk("R1", "load_en in reset", int'(load_en), 0);
    chk("R1", "valid in reset", int'(valid), 0);
    rst_n = 1'b1;
  endtask

  // One full run: cycle 0 carries the start pulse, later cycles are compared
  // against the arithmetic schedule.
  task automatic run_seq(input int mode, input bit poke);
    bit ev = 1'b0;
    bit el = 1'b0;
    int beats = 0;
    int init_steps = 0;
    int auth_steps = 0;
    int stalls = 0;
    for (int n = 0; n < OPER_START + OPER_RUN; n++) begin
      @(negedge clk);
      start = (n == 0) || (poke && (n == 10 || n == OPER_START + 3));
      ready = (exp_phase(n) == 4) ? ready_pat(mode, n) : 1'b1;
      #1;
      begin
        int ep = exp_phase(n);
        bit es;
        if (ep == 2)      es = ((n - 2) % D) == D - 1;
        else if (ep == 3) es = 1'b1;
        else if (ep == 4) es = !ev || ready;
        else              es = 1'b0;
        chk(phase_req(ep), "phase", int'(phase), ep);
        chk(phase_req(ep), "step_en", int'(step_en), int'(es));
        chk("R2", "load_en", int'(load_en), int'(ep == 1));
        if (ep < 4) chk("R4", "valid in warm-up", int'(valid), 0);
        else        chk("R6", "valid", int'(valid), int'(ev));
        if (ev) chk("R8", "tag_last", int'(tlast), int'(el));
        if (ev && !ready) stalls++;
        if (ep == 2 && step_en) init_steps++;
        if (ep == 3 && step_en) auth_steps++;
        if (ev && !ready && step_en) chk("R7", "step while stalled", 1, 0);
        if (ep == 4) begin
          if (es) begin
            beats++;
            ev = 1'b1;
            el = (beats % T) == 0;
          end else if (ready) begin
            ev = 1'b0;
          end
        end
      end
    end
    start = 1'b0;
    chk("R10", "warm-up step count", init_steps, I);
    chk("R5", "fill step count", auth_steps, A);
    if (mode != 0) chk("R7", "stall cycles seen", int'(stalls > 0), 1);
    if (poke) chk("R9", "phase after stray starts", int'(phase), 4);
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // idle holds without a start (R1)
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); #1;
      chk("R1", "idle phase hold", int'(phase), 0);
      chk("R1", "idle step_en", int'(step_en), 0);
    end
    run_seq(0, 1'b0);
    do_reset();
    run_seq(1, 1'b1);
    do_reset();
    run_seq(2, 1'b0);
    do_reset();
    run_seq(2, 1'b1);
    do_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule